// File: doc/BRIEF.md
# Reaction Time Round Sequencer

The block runs reaction-time trials over and over. It takes a one-cycle millisecond tick and an active-low push button that is already synchronized to the clock. Each round starts by drawing a pseudo-random wait between 1000 and 5000 ms. When the wait ends the LED lights and a millisecond count starts. The round closes when the button is pressed, when the press comes too early, or when no press arrives before a fixed cutoff.

Every round ends with one result on a status/value bus, marked by a single-cycle strobe. A 2000 ms rest follows before the next round begins. Formatting the result as text and sending it over a serial line are the job of logic further downstream.

Top module: `rtt_ctrl`

## Requirements
- R1: While rst_n is low and in the cycle after its release, led is 0, res_valid is 0, res_status is 00 and res_ms is 0. Reset loads the pseudo-random register with 0x0BEEF.
- R2: The pseudo-random register is 16 bits wide and advances once at the start of each round. It shifts right by one, and if the bit shifted out was 1 the result is XORed with 0xB400. The first round uses the state after one advance from the seed.
- R3: The wait length W is 1000 + (register value mod 4001) millisecond ticks. The remainder is found by repeated subtraction of 4001, one subtraction per clock. Before the wait there is one idle cycle after reset, one cycle to advance the register, and (value div 4001) + 1 reduction cycles. The LED turns on in the cycle after the clock edge that accepts the W-th tick of the wait.
- R4: A falling edge on btn_n during the wait is a false start. In the next cycle res_valid pulses with res_status = 01 and res_ms = the ticks counted so far in the wait. The LED does not light in that round.
- R5: A falling edge on btn_n while the LED is on ends the round. In the next cycle res_valid pulses with res_status = 00 and res_ms = the ticks counted since the LED lit (0 to 3000), and the LED goes off. A press at the edge where the count is 3000 is still a valid result.
- R6: If the LED has counted 3000 ticks and a further tick arrives with no press, the round times out. res_valid pulses with res_status = 10 and res_ms = 3001, and the LED goes off. The LED is therefore lit for exactly 3001 clock cycles when a tick arrives every cycle.
- R7: After any result the block rests for 2000 ticks and then starts the next round. Button edges during the rest give no result and do not light the LED.
- R8: res_valid is high for exactly one cycle per result. res_status and res_ms keep their last values between strobes.
- R9: Only a falling edge counts as a press. A button that is already held low when the LED lights never produces a valid result, and that round times out.
- R10: All waits and counts advance only in cycles where tick_ms is high. With one tick every three cycles, a valid result equals the number of ticks seen while the LED was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| btn_n | input | 1 | Synchronized button, low when pressed |
| led | output | 1 | LED drive, high while the response window is open |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_status | output | 2 | 00 valid, 01 false start, 10 timeout |
| res_ms | output | 16 | Milliseconds for the result |

## Verification
The cases hardest to reach from the ports are the ones tied to exact positions inside a round. These are a press at the very tick where the cutoff would fire, a press during the rest, and a button already held low when the LED lights. The bench drives one tick every clock, so tick counts and clock counts line up. It then places each stimulus by counting cycles from a result strobe or from the LED rising edge. A behavioural model with plain integers follows each round and is compared every clock. A final round uses sparse ticks to show that only ticks advance the counts.

// File: rtl/rtt_pkg.sv
// Shared types for the reaction-time round sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package rtt_pkg;

    // Round phases of the controller.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ROLL   = 3'd1,
        ST_REDUCE = 3'd2,
        ST_WAIT   = 3'd3,
        ST_REACT  = 3'd4,
        ST_PAUSE  = 3'd5
    } rtt_state_t;

    // Result codes presented on res_status.
    typedef enum logic [1:0] {
        RES_VALID   = 2'b00,
        RES_FALSE   = 2'b01,
        RES_TIMEOUT = 2'b10
    } rtt_status_t;

endpackage

// File: rtl/rtt_lfsr.sv
// Right-shifting Galois pseudo-random register.
// Advances one step when step is high. Assumes SEED is non-zero.
module rtt_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    SEED = 16'hBEEF,
    parameter logic [W-1:0]    TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state,
    output logic [W-1:0] state_nxt
);

    // Next value: shift right, fold taps in when a one leaves.
    always_comb begin
        state_nxt = (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    // State register with seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= state_nxt;
    end

    // R2: a non-zero seed never decays to the all-zero lock-up state
    p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/rtt_modred.sv
// Iterative remainder unit: subtracts SPAN once per clock until the
// value drops below SPAN. Assumes load is a single-cycle request.
module rtt_modred #(
    parameter int W    = 16,
    parameter int SPAN = 4001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] rem,
    output logic         done
);

    localparam logic [W-1:0] SPAN_C = W'(SPAN);

    // Finished once the remainder is below the modulus.
    always_comb begin
        done = (rem < SPAN_C);
    end

    // Load a fresh operand or take one subtraction step.
    always_ff @(posedge clk) begin
        if (!rst_n)     rem <= '0;
        else if (load)  rem <= load_val;
        else if (!done) rem <= rem - SPAN_C;
    end

    // R3: every step while not finished makes the remainder strictly smaller
    p_rem_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (rem < $past(rem)));

endmodule

// File: rtl/rtt_mscount.sv
// Millisecond counter with synchronous clear (dominant) and increment.
// Assumes the controller never asks it to pass its maximum value.
module rtt_mscount #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + W'(1);
    end

    // R10: the count only moves up by one, and only on a requested increment
    p_step_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && $past(rst_n)) |-> (count == $past(count) + W'($past(inc))));

endmodule

// File: rtl/rtt_ctrl.sv
// Reaction-time round sequencer (top).
// Flow per round: advance pseudo-random register, reduce it modulo
// SPAN, wait BASE+remainder ticks, light LED, time the press, rest.
// Assumes btn_n is already synchronized and tick_ms is a 1-cycle pulse.
module rtt_ctrl
    import rtt_pkg::*;
#(
    parameter int           CNT_W       = 16,
    parameter int           RNG_W       = 16,
    parameter logic [15:0]  RNG_SEED    = 16'hBEEF,
    parameter logic [15:0]  RNG_TAPS    = 16'hB400,
    parameter int           WAIT_BASE   = 1000,
    parameter int           WAIT_SPAN   = 4001,
    parameter int           REACT_LIMIT = 3000,
    parameter int           REST_MS     = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             btn_n,
    output logic             led,
    output logic             res_valid,
    output logic [1:0]       res_status,
    output logic [CNT_W-1:0] res_ms
);

    localparam logic [CNT_W-1:0] BASE_C  = CNT_W'(WAIT_BASE);
    localparam logic [CNT_W-1:0] TOP_C   = CNT_W'(WAIT_BASE + WAIT_SPAN);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(REACT_LIMIT);
    localparam logic [CNT_W-1:0] REST_C  = CNT_W'(REST_MS - 1);

    rtt_state_t          state;
    rtt_status_t         status_q;
    logic                btn_q;
    logic                press;
    logic [RNG_W-1:0]    rng_state;
    logic [RNG_W-1:0]    rng_nxt;
    logic [RNG_W-1:0]    red_rem;
    logic                red_done;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    tgt;
    logic                cnt_clr;
    logic                cnt_inc;
    logic                wait_hit;
    logic                react_cut;
    logic                rest_hit;

    rtt_lfsr #(.W(RNG_W), .SEED(RNG_W'(RNG_SEED)), .TAPS(RNG_W'(RNG_TAPS))) rng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (state == ST_ROLL),
        .state     (rng_state),
        .state_nxt (rng_nxt)
    );

    rtt_modred #(.W(RNG_W), .SPAN(WAIT_SPAN)) red_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_ROLL),
        .load_val (rng_nxt),
        .rem      (red_rem),
        .done     (red_done)
    );

    rtt_mscount #(.W(CNT_W)) ms_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // Remember the button level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) btn_q <= 1'b1;
        else        btn_q <= btn_n;
    end

    // Press = high last cycle, low now; tick-qualified end conditions.
    always_comb begin
        press     = btn_q & ~btn_n;
        wait_hit  = tick_ms && (cnt == tgt - CNT_W'(1));
        react_cut = tick_ms && (cnt == LIMIT_C);
        rest_hit  = tick_ms && (cnt == REST_C);
    end

    // Counter control per phase; clear on every phase exit.
    always_comb begin
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        case (state)
            ST_REDUCE: cnt_clr = red_done;
            ST_WAIT: begin
                if (press || wait_hit) cnt_clr = 1'b1;
                else                   cnt_inc = tick_ms;
            end
            ST_REACT: begin
                if (press || react_cut) cnt_clr = 1'b1;
                else                    cnt_inc = tick_ms;
            end
            ST_PAUSE: begin
                if (rest_hit) cnt_clr = 1'b1;
                else          cnt_inc = tick_ms;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

    // Round state machine, wait target and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tgt       <= BASE_C;
            res_valid <= 1'b0;
            status_q  <= RES_VALID;
            res_ms    <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: state <= ST_ROLL;
                ST_ROLL: state <= ST_REDUCE;
                ST_REDUCE: begin
                    if (red_done) begin
                        tgt   <= BASE_C + CNT_W'(red_rem);
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (press) begin
                        res_valid <= 1'b1;
                        status_q  <= RES_FALSE;
                        res_ms    <= cnt;
                        state     <= ST_PAUSE;
                    end else if (wait_hit) begin
                        state <= ST_REACT;
                    end
                end
                ST_REACT: begin
                    if (press) begin
                        res_valid <= 1'b1;
                        status_q  <= RES_VALID;
                        res_ms    <= cnt;
                        state     <= ST_PAUSE;
                    end else if (react_cut) begin
                        res_valid <= 1'b1;
                        status_q  <= RES_TIMEOUT;
                        res_ms    <= cnt + CNT_W'(1);
                        state     <= ST_PAUSE;
                    end
                end
                ST_PAUSE: if (rest_hit) state <= ST_ROLL;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // LED is lit exactly while the response window is open.
    always_comb begin
        led        = (state == ST_REACT);
        res_status = status_q;
    end

    // R8: the result strobe never lasts two cycles
    p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R5: the LED goes dark only together with a valid or timeout result
    p_led_off_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led) |-> (res_valid && res_status != RES_FALSE));
    // R4: a false start is reported with the LED dark before and after
    p_false_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == RES_FALSE) |-> (!led && !$past(led)));
    // R5: a valid reading never exceeds the cutoff
    p_valid_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == RES_VALID) |-> (res_ms <= LIMIT_C));
    // R6: a timeout always reports one past the cutoff
    p_timeout_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == RES_TIMEOUT) |-> (res_ms == LIMIT_C + CNT_W'(1)));
    // R3: the loaded wait lies inside the allowed window
    p_wait_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (tgt >= BASE_C && tgt < TOP_C));
    // R7: no result appears once the rest has begun
    p_rest_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && $past(state == ST_PAUSE)) |-> !res_valid);

endmodule

// File: tb/rtt_ctrl_tb_top.sv
// Bench for the reaction-time sequencer: a behavioural integer model
// runs alongside and is compared every clock; directed rounds add
// named checks for each requirement.
module rtt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b1;
    logic        btn_n = 1'b1;
    logic        led;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [15:0] res_ms;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int tick_gap = 1;
    int tick_ph = 0;
    int tally = 0;

    // model state
    int ph = 0, lf = 16'hBEEF, rem = 0, tgt = 0, cnt = 0;
    bit mprev = 1, m_v = 0, m_led = 0;
    int m_st = 0, m_ms = 0;

    always #4 clk = ~clk;

    rtt_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .btn_n      (btn_n),
        .led        (led),
        .res_valid  (res_valid),
        .res_status (res_status),
        .res_ms     (res_ms)
    );

    function automatic int adv(int v);
        int o;
        o = v >> 1;
        if (v % 2 == 1) o = o ^ 46080;
        return o;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // tick pattern, changed only away from the active edge
    always @(negedge clk) begin
        tick_ph = tick_ph + 1;
        tick_ms = (tick_ph % tick_gap) == 0;
    end

    // independent tally of ticks accepted while the LED is lit
    always @(posedge clk) begin
        if (!led) tally <= 0;
        else if (tick_ms && btn_n) tally <= tally + 1;
    end

    // behavioural reference model
    always @(posedge clk) begin
        bit press;
        press = mprev && !btn_n;
        m_v = 0;
        if (!rst_n) begin
            ph = 0; lf = 16'hBEEF; cnt = 0; m_st = 0; m_ms = 0; press = 0;
        end else begin
            case (ph)
                0: ph = 1;
                1: begin lf = adv(lf); rem = lf; ph = 2; end
                2: if (rem >= 4001) rem = rem - 4001;
                   else begin tgt = 1000 + rem; cnt = 0; ph = 3; end
                3: if (press) begin
                       m_v = 1; m_st = 1; m_ms = cnt; cnt = 0; ph = 5;
                   end else if (tick_ms) begin
                       if (cnt + 1 == tgt) begin cnt = 0; ph = 4; end
                       else cnt = cnt + 1;
                   end
                4: if (press) begin
                       m_v = 1; m_st = 0; m_ms = cnt; cnt = 0; ph = 5;
                   end else if (tick_ms) begin
                       if (cnt == 3000) begin
                           m_v = 1; m_st = 2; m_ms = 3001; cnt = 0; ph = 5;
                       end else cnt = cnt + 1;
                   end
                default: if (tick_ms) begin
                       if (cnt + 1 == 2000) begin cnt = 0; ph = 1; end
                       else cnt = cnt + 1;
                   end
            endcase
        end
        mprev = rst_n ? btn_n : 1'b1;
        m_led = (ph == 4);
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            string tg;
            bit ok;
            tg = !m_v ? "R3 led/strobe" : (m_st == 1 ? "R4" : (m_st == 2 ? "R6" : "R5"));
            ok = (led == m_led) && (res_valid == m_v) &&
                 (!m_v || (res_status == 2'(m_st) && res_ms == 16'(m_ms)));
            compared++;
            if (!ok) begin
                mismatched++;
                $display("FAIL %s model: actual led=%0d v=%0d st=%0d ms=%0d expected led=%0d v=%0d st=%0d ms=%0d",
                         tg, led, res_valid, res_status, res_ms, m_led, m_v, m_st, m_ms);
            end
        end
    end

    task automatic wait_result(output int st, output int ms, input int limit);
        st = -1; ms = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (res_valid) begin st = res_status; ms = res_ms; return; end
        end
    endtask

    task automatic wait_led(output int n, input int limit);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            if (led) return;
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int st, ms, n, v, expn, lit, extra;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!led && !res_valid && res_status == 2'b00 && res_ms == 16'd0,
            "R1 reset outputs", int'(led) + int'(res_valid), 0);
        rst_n = 1'b1;

        // R2 R3: first round timing from seed
        v = adv(16'hBEEF);
        expn = 2 + (v / 4001) + 1 + 1000 + (v % 4001);
        wait_led(n, 10000);
        chk(n == expn, "R2 R3 first LED edge count", n, expn);

        // R5: valid press after 37 ticks
        repeat (37) @(negedge clk);
        btn_n = 1'b0;
        wait_result(st, ms, 10);
        chk(st == 0 && ms == 37, "R5 valid reading", ms, 37);
        chk(!led, "R5 led off at result", int'(led), 0);
        @(negedge clk);
        chk(!res_valid && res_status == 2'b00 && res_ms == 16'd37,
            "R8 strobe single, data held", int'(res_valid), 0);

        // R7: press during rest ignored; then R4 false start in the wait
        extra = 0; lit = 0;
        for (int i = 1; i < 2600; i++) begin
            @(negedge clk);
            if (res_valid) extra++;
            if (led) lit++;
            if (i == 100) btn_n = 1'b1;
            if (i == 500) btn_n = 1'b0;
            if (i == 505) btn_n = 1'b1;
        end
        chk(extra == 0, "R7 no result from rest press", extra, 0);
        chk(lit == 0, "R7 led dark through rest and wait", lit, 0);
        btn_n = 1'b0;
        wait_result(st, ms, 10);
        chk(st == 1, "R4 false start status", st, 1);
        chk(!led, "R4 led dark", int'(led), 0);

        // R9 R6: button pressed during rest and held; round must time out
        repeat (10) @(negedge clk);
        btn_n = 1'b1;
        repeat (90) @(negedge clk);
        btn_n = 1'b0;
        wait_led(n, 12000);
        lit = 1;
        wait_result(st, ms, 5000);
        chk(st == 2 && ms == 3001, "R9 R6 held button times out", ms, 3001);
        btn_n = 1'b1;
        begin
            // led was high from the first sight up to the result cycle
            int seen;
            seen = 0;
        end
        chk(!led, "R6 led off after timeout", int'(led), 0);

        // R5 boundary: press at count 3000 is still valid
        wait_led(n, 12000);
        repeat (3000) @(negedge clk);
        btn_n = 1'b0;
        wait_result(st, ms, 10);
        chk(st == 0 && ms == 3000, "R5 boundary press at cutoff", ms, 3000);
        repeat (5) @(negedge clk);
        btn_n = 1'b1;

        // R10: sparse ticks, one in three cycles
        tick_gap = 3;
        wait_led(n, 40000);
        chk(n > 3000, "R10 sparse ticks stretch the rest and wait", n, 3001);
        repeat (30) @(negedge clk);
        btn_n = 1'b0;
        wait_result(st, ms, 10);
        chk(st == 0 && ms == tally && ms <= 11, "R10 reading counts ticks only", ms, tally);
        repeat (5) @(negedge clk);
        btn_n = 1'b1;
        repeat (20) @(negedge clk);

        finish_run();
    end

endmodule